// File: doc/BRIEF.md
# Floating-Point Exception Queue Recorder

This block keeps a record of floating-point exceptions. When the pipeline reports an exception, it presents a request. The request carries a trap-type code, a mask of cause bits, and the 32-bit instruction word that faulted. The fetch of that word happens outside this block. On an accepted request, the block writes one record into the lowest-numbered free slot of a small queue. It also updates two fields of floating-point status register 0: the trap-type field and the queue-not-empty flag.

Every record holds these fields:

- a valid bit
- the trap type
- the cause mask
- the faulting opcode
- an origin tag, fixed to the float code
- an interrupt-slot tag, fixed to the nil code

When the queue is full, a request has no effect at all. A synchronous clear input empties the queue. The `noq_mode` configuration input selects the variant without a queue. In that variant, a request changes only the trap-type field of the status register.

Occupancy is tracked by a three-state machine:

| State | Meaning |
|---|---|
| OCC_EMPTY | no record is held |
| OCC_SOME | at least one record is held and a slot is free |
| OCC_FULL | every slot holds a record |

| Transition | From | To | Condition |
|---|---|---|---|
| T_FIRST | OCC_EMPTY | OCC_SOME | an accepted record leaves a slot free |
| T_FILL_ONE | OCC_EMPTY | OCC_FULL | an accepted record fills a single-slot queue |
| T_FILL | OCC_SOME | OCC_FULL | an accepted record takes the last free slot |
| T_CLEAR | any state | OCC_EMPTY | the clear input is high |

In every other case the state holds.

Top module: `fpx_queue_recorder`

## Requirements
- R1: After reset, all slots are invalid and every field of every slot is zero. The queue-not-empty flag is 0, and the status trap-type field is 0.
- R2: While `noq_mode` is 1, a request sets the status trap-type field to `rec_trap` on the next cycle. No slot and no queue-not-empty flag changes.
- R3: The queue has NQ = 10 slots, numbered 0 to 9. Ten accepted requests after a clear make all ten valid bits 1.
- R4: An accepted request writes the lowest-numbered slot whose valid bit is 0.
- R5: A written slot has the following contents:
  - valid = 1
  - trap = `rec_trap`
  - cause = `rec_cause`
  - opcode = `rec_opcode`
  - origin = 2'b01 (float)
  - interrupt-slot = 2'b00 (nil)
- R6: The cycle after an accepted request, the queue-not-empty flag is 1 and the status trap-type field equals the request's trap type.
- R7: When all slots are valid, a request changes nothing, including the status trap-type field.
- R8: `sw_clear` zeroes all slots and drops the queue-not-empty flag on the next cycle, and keeps the status trap-type field. It takes priority over a request in the same cycle, which is then dropped.
- R9: Each accepted request makes exactly one more slot valid, and leaves every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| noq_mode | input | 1 | 1 selects the variant without a queue |
| sw_clear | input | 1 | synchronous clear of the queue |
| rec_req | input | 1 | record request |
| rec_trap | input | TT_W | trap-type code of the exception |
| rec_cause | input | CX_W | cause mask of the exception |
| rec_opcode | input | OP_W | instruction word fetched at the faulting address |
| ent_valid | output | NQ | valid bit of each slot |
| ent_trap | output | NQ*TT_W | trap type of each slot, slot i at bits [i*TT_W +: TT_W] |
| ent_cause | output | NQ*CX_W | cause mask of each slot, slot i at bits [i*CX_W +: CX_W] |
| ent_opcode | output | NQ*OP_W | opcode of each slot, slot i at bits [i*OP_W +: OP_W] |
| ent_origin | output | NQ*2 | origin tag of each slot |
| ent_slot | output | NQ*2 | interrupt-slot tag of each slot |
| fsr_qne | output | 1 | status register 0: queue-not-empty flag |
| fsr_trap | output | TT_W | status register 0: trap-type field |

## Verification
The assertions check several properties on every cycle:

- The full state agrees with the valid bits.
- A picked slot is always free.
- Each accepted record adds exactly one valid bit, sets the flag and copies the trap type.
- A request against a full queue, or in the variant without a queue, leaves the slots alone.
- A clear empties the queue.

Only the bench scenarios can show the rest: that the lowest free slot is the one chosen, that the opcode and cause land in the right slot, and that the trap-type field survives a clear and a rejected request. These are compared field by field against a reference model.

// File: rtl/fpxq_pkg.sv
package fpxq_pkg;

    // Width of the origin tag and of the interrupt-slot tag.
    localparam int TAG_W = 2;

    // Origin code stored in every record written by this block.
    localparam logic [TAG_W-1:0] ORIGIN_FLOAT = 2'b01;

    // Interrupt-slot code stored in every record written by this block.
    localparam logic [TAG_W-1:0] ISLOT_NIL = 2'b00;

    // Occupancy classes of the queue.
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'b00,
        OCC_SOME  = 2'b01,
        OCC_FULL  = 2'b10
    } occ_state_t;

endpackage

// File: rtl/fpxq_slot_pick.sv
module fpxq_slot_pick #(
    parameter int NQ    = 10,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NQ-1:0]    valid,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Lowest free index wins: scan from the top down so the lowest free slot is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    // R4: a picked slot is never one already in use.
    a_r4_pick_free : assert property (@(posedge clk) disable iff (!rst_n)
        found |-> !valid[idx]);

endmodule

// File: rtl/fpxq_entry.sv
module fpxq_entry
    import fpxq_pkg::*;
#(
    parameter int TT_W = 3,
    parameter int CX_W = 6,
    parameter int OP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [TT_W-1:0]  trap_in,
    input  logic [CX_W-1:0]  cause_in,
    input  logic [OP_W-1:0]  op_in,
    output logic             valid_q,
    output logic [TT_W-1:0]  trap_q,
    output logic [CX_W-1:0]  cause_q,
    output logic [OP_W-1:0]  op_q,
    output logic [TAG_W-1:0] org_q,
    output logic [TAG_W-1:0] islot_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            trap_q  <= '0;
            cause_q <= '0;
            op_q    <= '0;
            org_q   <= '0;
            islot_q <= '0;
        end else if (clr) begin
            valid_q <= 1'b0;
            trap_q  <= '0;
            cause_q <= '0;
            op_q    <= '0;
            org_q   <= '0;
            islot_q <= '0;
        end else if (wr) begin
            valid_q <= 1'b1;
            trap_q  <= trap_in;
            cause_q <= cause_in;
            op_q    <= op_in;
            org_q   <= ORIGIN_FLOAT;
            islot_q <= ISLOT_NIL;
        end
    end

    // R9: an occupied slot is never rewritten.
    a_r9_no_overwrite : assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !clr) |=> (valid_q && $stable(op_q) && $stable(trap_q)));

endmodule

// File: rtl/fpxq_occ_fsm.sv
module fpxq_occ_fsm
    import fpxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic accept,
    input  logic last_free,
    output logic qne,
    output logic full
);

    occ_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = OCC_EMPTY;                                   // T_CLEAR
        end else begin
            unique case (state_q)
                OCC_EMPTY: if (accept) state_d = last_free ? OCC_FULL : OCC_SOME; // T_FIRST / T_FILL_ONE
                OCC_SOME:  if (accept && last_free) state_d = OCC_FULL;           // T_FILL
                OCC_FULL:  state_d = OCC_FULL;
                default:   state_d = OCC_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        qne  = 1'b0;
        full = 1'b0;
        unique case (state_q)
            OCC_EMPTY: begin qne = 1'b0; full = 1'b0; end
            OCC_SOME:  begin qne = 1'b1; full = 1'b0; end
            OCC_FULL:  begin qne = 1'b1; full = 1'b1; end
            default:   begin qne = 1'b0; full = 1'b0; end
        endcase
    end

    // R8: a clear always leaves the machine empty.
    a_r8_clear_empty : assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !qne);

    // R7: a full queue is left only through a clear.
    a_r7_full_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> full);

endmodule

// File: rtl/fpx_queue_recorder.sv
module fpx_queue_recorder
    import fpxq_pkg::*;
#(
    parameter int NQ   = 10,
    parameter int TT_W = 3,
    parameter int CX_W = 6,
    parameter int OP_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               noq_mode,
    input  logic               sw_clear,
    input  logic               rec_req,
    input  logic [TT_W-1:0]    rec_trap,
    input  logic [CX_W-1:0]    rec_cause,
    input  logic [OP_W-1:0]    rec_opcode,
    output logic [NQ-1:0]      ent_valid,
    output logic [NQ*TT_W-1:0] ent_trap,
    output logic [NQ*CX_W-1:0] ent_cause,
    output logic [NQ*OP_W-1:0] ent_opcode,
    output logic [NQ*2-1:0]    ent_origin,
    output logic [NQ*2-1:0]    ent_slot,
    output logic               fsr_qne,
    output logic [TT_W-1:0]    fsr_trap
);

    localparam int IDX_W = (NQ > 1) ? $clog2(NQ) : 1;

    logic             found;
    logic [IDX_W-1:0] pick_idx;
    logic             accept;
    logic             noq_write;
    logic             last_free;
    logic             full;
    logic [NQ-1:0]    wr_vec;
    logic [TT_W-1:0]  trap_q;

    fpxq_slot_pick #(.NQ(NQ), .IDX_W(IDX_W)) pick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (ent_valid),
        .found (found),
        .idx   (pick_idx)
    );

    // In queue mode a request is accepted only when a slot is free; a clear takes priority.
    assign accept    = rec_req && !sw_clear && !noq_mode && found;
    assign noq_write = rec_req && !sw_clear && noq_mode;
    assign last_free = ($countones(ent_valid) == NQ - 1);

    always_comb begin
        wr_vec = '0;
        if (accept) wr_vec[pick_idx] = 1'b1;
    end

    for (genvar g = 0; g < NQ; g++) begin : g_slot
        fpxq_entry #(.TT_W(TT_W), .CX_W(CX_W), .OP_W(OP_W)) ent_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (sw_clear),
            .wr       (wr_vec[g]),
            .trap_in  (rec_trap),
            .cause_in (rec_cause),
            .op_in    (rec_opcode),
            .valid_q  (ent_valid[g]),
            .trap_q   (ent_trap[g*TT_W +: TT_W]),
            .cause_q  (ent_cause[g*CX_W +: CX_W]),
            .op_q     (ent_opcode[g*OP_W +: OP_W]),
            .org_q    (ent_origin[g*TAG_W +: TAG_W]),
            .islot_q  (ent_slot[g*TAG_W +: TAG_W])
        );
    end

    fpxq_occ_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sw_clear),
        .accept    (accept),
        .last_free (last_free),
        .qne       (fsr_qne),
        .full      (full)
    );

    // Trap-type field of status register 0; a clear leaves it as it is.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     trap_q <= '0;
        else if (accept || noq_write)   trap_q <= rec_trap;
    end
    assign fsr_trap = trap_q;

    // R3: the full state matches every slot being valid.
    a_r3_full_match : assert property (@(posedge clk) disable iff (!rst_n)
        full == (&ent_valid));

    // R6: an accepted request raises the flag and copies the trap type.
    a_r6_status_update : assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (fsr_qne && fsr_trap == $past(rec_trap)));

    // R9: an accepted request adds exactly one valid slot.
    a_r9_one_more : assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ($countones(ent_valid) == $countones($past(ent_valid)) + 1));

    // R2: the variant without a queue never touches a slot.
    a_r2_noq_slots : assert property (@(posedge clk) disable iff (!rst_n)
        (noq_mode && !sw_clear) |=> $stable(ent_valid));

    // R7: a request against a full queue leaves slots and trap type alone.
    a_r7_full_ignored : assert property (@(posedge clk) disable iff (!rst_n)
        (rec_req && full && !sw_clear && !noq_mode) |=> ($stable(ent_valid) && $stable(fsr_trap)));

    // R8: a clear empties every slot.
    a_r8_clear_slots : assert property (@(posedge clk) disable iff (!rst_n)
        sw_clear |=> (ent_valid == '0));

endmodule

// File: tb/fpx_queue_recorder_tb_top.sv
module fpx_queue_recorder_tb_top;

    localparam int CLK_P = 10;
    localparam int NQ    = 10;
    localparam int TT_W  = 3;
    localparam int CX_W  = 6;
    localparam int OP_W  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic noq_mode = 1'b0;
    logic sw_clear = 1'b0;
    logic rec_req = 1'b0;
    logic [TT_W-1:0] rec_trap = '0;
    logic [CX_W-1:0] rec_cause = '0;
    logic [OP_W-1:0] rec_opcode = '0;
    logic [NQ-1:0]      ent_valid;
    logic [NQ*TT_W-1:0] ent_trap;
    logic [NQ*CX_W-1:0] ent_cause;
    logic [NQ*OP_W-1:0] ent_opcode;
    logic [NQ*2-1:0]    ent_origin;
    logic [NQ*2-1:0]    ent_slot;
    logic               fsr_qne;
    logic [TT_W-1:0]    fsr_trap;

    int total = 0;
    int bad   = 0;
    bit running = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fpx_queue_recorder #(.NQ(NQ), .TT_W(TT_W), .CX_W(CX_W), .OP_W(OP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .noq_mode(noq_mode), .sw_clear(sw_clear),
        .rec_req(rec_req), .rec_trap(rec_trap), .rec_cause(rec_cause), .rec_opcode(rec_opcode),
        .ent_valid(ent_valid), .ent_trap(ent_trap), .ent_cause(ent_cause),
        .ent_opcode(ent_opcode), .ent_origin(ent_origin), .ent_slot(ent_slot),
        .fsr_qne(fsr_qne), .fsr_trap(fsr_trap)
    );

    // Behavioural reference model.
    bit          m_v   [NQ];
    int unsigned m_tt  [NQ];
    int unsigned m_cx  [NQ];
    int unsigned m_op  [NQ];
    int unsigned m_org [NQ];
    int unsigned m_sl  [NQ];
    bit          m_qne;
    int unsigned m_trap;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NQ; i++) begin
                m_v[i] <= 0; m_tt[i] <= 0; m_cx[i] <= 0; m_op[i] <= 0; m_org[i] <= 0; m_sl[i] <= 0;
            end
            m_qne <= 0; m_trap <= 0;
        end else if (sw_clear) begin
            for (int i = 0; i < NQ; i++) begin
                m_v[i] <= 0; m_tt[i] <= 0; m_cx[i] <= 0; m_op[i] <= 0; m_org[i] <= 0; m_sl[i] <= 0;
            end
            m_qne <= 0;
        end else if (rec_req) begin
            if (noq_mode) begin
                m_trap <= rec_trap;
            end else begin
                int slot;
                slot = -1;
                for (int i = 0; i < NQ; i++) if (slot < 0 && !m_v[i]) slot = i;
                if (slot >= 0) begin
                    m_v[slot] <= 1; m_tt[slot] <= rec_trap; m_cx[slot] <= rec_cause;
                    m_op[slot] <= rec_opcode; m_org[slot] <= 1; m_sl[slot] <= 0;
                    m_qne <= 1; m_trap <= rec_trap;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint unsigned act, input longint unsigned exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (running) begin
            for (int i = 0; i < NQ; i++) begin
                check(ent_valid[i] == m_v[i], "R4 valid", ent_valid[i], m_v[i]);
                check(ent_trap[i*TT_W +: TT_W] == m_tt[i], "R5 trap", ent_trap[i*TT_W +: TT_W], m_tt[i]);
                check(ent_cause[i*CX_W +: CX_W] == m_cx[i], "R5 cause", ent_cause[i*CX_W +: CX_W], m_cx[i]);
                check(ent_opcode[i*OP_W +: OP_W] == m_op[i], "R5 opcode", ent_opcode[i*OP_W +: OP_W], m_op[i]);
                check(ent_origin[i*2 +: 2] == m_org[i], "R5 origin", ent_origin[i*2 +: 2], m_org[i]);
                check(ent_slot[i*2 +: 2] == m_sl[i], "R5 islot", ent_slot[i*2 +: 2], m_sl[i]);
            end
            check(fsr_qne == m_qne, "R6 qne", fsr_qne, m_qne);
            check(fsr_trap == m_trap, "R6 trap", fsr_trap, m_trap);
        end
    end

    task automatic drive(input bit req, input int t, input int c, input int unsigned op, input bit clr);
        @(posedge clk); #1;
        rec_req = req; rec_trap = TT_W'(t); rec_cause = CX_W'(c); rec_opcode = op; sw_clear = clr;
    endtask

    task automatic idle_sample();
        drive(0, 0, 0, 0, 0);
        @(negedge clk);
    endtask

    initial begin
        fork
            begin
                #(CLK_P * 3 + 2);
                rst_n = 1'b1;
                running = 1'b1;
                @(negedge clk);
                // R1: reset state
                check(ent_valid == '0 && ent_opcode == '0 && ent_trap == '0, "R1 slots", ent_valid, 0);
                check(fsr_qne == 0 && fsr_trap == 0, "R1 status", {fsr_qne, fsr_trap}, 0);

                // R4/R5/R6: three records, distinct patterns
                drive(1, 3, 6'h21, 32'hDEADBEEF, 0);
                drive(1, 5, 6'h0C, 32'h12345678, 0);
                drive(1, 2, 6'h3F, 32'h0BADF00D, 0);
                idle_sample();
                check(ent_valid == 10'b0000000111, "R4 lowest slots", ent_valid, 10'b111);
                check(ent_opcode[1*OP_W +: OP_W] == 32'h12345678, "R5 slot1 opcode", ent_opcode[1*OP_W +: OP_W], 32'h12345678);
                check(ent_origin[0 +: 2] == 2'b01 && ent_slot[0 +: 2] == 2'b00, "R5 tags", {ent_origin[1:0], ent_slot[1:0]}, 4'b0100);
                check(fsr_qne && fsr_trap == 2, "R6 status", {fsr_qne, fsr_trap}, {1'b1, 3'd2});

                // R8: clear, then clear together with a request
                drive(0, 0, 0, 0, 1);
                drive(1, 7, 6'h01, 32'hAAAA5555, 1);
                idle_sample();
                check(ent_valid == '0 && !fsr_qne, "R8 cleared", {ent_valid, fsr_qne}, 0);
                check(fsr_trap == 2, "R8 trap kept", fsr_trap, 2);

                // R3/R9: fill all ten slots
                for (int k = 0; k < NQ; k++) drive(1, k % 8, k * 5, 32'hC0DE0000 + k, 0);
                idle_sample();
                check(ent_valid == {NQ{1'b1}}, "R3 all valid", ent_valid, {NQ{1'b1}});
                check(ent_opcode[9*OP_W +: OP_W] == 32'hC0DE0009, "R3 slot9 opcode", ent_opcode[9*OP_W +: OP_W], 32'hC0DE0009);

                // R7: request against a full queue
                drive(1, 6, 6'h15, 32'hFFFF0000, 0);
                idle_sample();
                check(fsr_trap == 1, "R7 trap unchanged", fsr_trap, 1);
                check(ent_opcode[0 +: OP_W] == 32'hC0DE0000, "R7 slot0 intact", ent_opcode[0 +: OP_W], 32'hC0DE0000);

                // R2: variant without a queue
                drive(0, 0, 0, 0, 1);
                drive(0, 0, 0, 0, 0);
                noq_mode = 1'b1;
                drive(1, 4, 6'h2A, 32'h55555555, 0);
                drive(1, 6, 6'h11, 32'h66666666, 0);
                idle_sample();
                check(fsr_trap == 6, "R2 trap written", fsr_trap, 6);
                check(ent_valid == '0 && !fsr_qne, "R2 queue untouched", {ent_valid, fsr_qne}, 0);
                noq_mode = 1'b0;

                // R4/R9: record after mode switch lands in slot 0
                drive(1, 1, 6'h02, 32'h77777777, 0);
                idle_sample();
                check(ent_valid == 10'b1, "R9 one slot", ent_valid, 1);
                repeat (3) idle_sample();
            end
            begin
                #(CLK_P * 20000);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        running = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule